// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Stall Unit

This block is the hazard-resolution logic of a five-stage in-order pipeline. Each cycle it compares the source register numbers of the instruction in the execute stage with the destination numbers of the two older instructions in the memory and write-back stages. From those comparisons it drives one operand-select code for each ALU input. Each code picks the register-file value, the result waiting in the memory stage, or the result waiting in the write-back stage.

It also compares the destination of a load in the execute stage with the sources of the instruction being decoded. If they match, it freezes the program counter and the fetch/decode register, and it zeroes the control word entering the execute stage. One bubble is inserted this way. On the following cycle the bubble sits in execute, the stall releases, and the loaded value later reaches the dependent instruction through the write-back bypass.

All outputs are combinational functions of the present inputs.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (memory-stage result) when memRegWrite is 1, memRd is nonzero and memRd equals that operand's source register (exRs for A, exRt for B).
- R2: An operand select is 2'b01 (write-back result) when wbRegWrite is 1, wbRd is nonzero, wbRd equals the operand's source and the R1 condition for that operand is false. When both stages match, the memory stage wins.
- R3: A destination of register 0 never produces a bypass, whatever the write flags.
- R4: A stage whose write flag is 0 never produces a bypass, even when its destination matches.
- R5: When no bypass condition holds, the select is 2'b00 (register file). The code 2'b11 is never produced.
- R6: A load-use stall is raised when exMemRead is 1 and exRt equals idRs or idRt. Register 0 is not excluded from this comparison.
- R7: During a stall pcWriteEn=0, ifidWriteEn=0 and idexCtrlZero=1. Otherwise pcWriteEn=1, ifidWriteEn=1 and idexCtrlZero=0.
- R8: No stall is raised while exMemRead is 0, even when the registers match.
- R9: Select A depends only on exRs and select B depends only on exRt. The two operands resolve independently in the same cycle.
- R10: A load followed by a dependent instruction costs exactly one stall cycle. The cycle after the stall shows no stall with the bubble in execute. When the dependent instruction reaches execute with the load in write-back, its operand select is 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idRs | input | 5 | First source register of the instruction in decode |
| idRt | input | 5 | Second source register of the instruction in decode |
| exRs | input | 5 | First source register of the instruction in execute |
| exRt | input | 5 | Second source register (and load destination) in execute |
| exMemRead | input | 1 | Instruction in execute is a load |
| memRd | input | 5 | Selected destination of the instruction in the memory stage |
| memRegWrite | input | 1 | Instruction in the memory stage writes a register |
| wbRd | input | 5 | Selected destination of the instruction in write-back |
| wbRegWrite | input | 1 | Instruction in write-back writes a register |
| fwdSelA | output | 2 | Select for ALU input A: 00 file, 10 memory stage, 01 write-back |
| fwdSelB | output | 2 | Select for ALU input B, same encoding |
| pcWriteEn | output | 1 | Program counter update enable, low during a stall |
| ifidWriteEn | output | 1 | Fetch/decode register update enable, low during a stall |
| idexCtrlZero | output | 1 | Forces the control word entering execute to zero |

## Verification
Directed patterns cover the following cases:
- a single match in either stage;
- both stages matching the same source, which must give the memory-stage result;
- register-0 destinations with both write flags set;
- matching destinations whose write flags are clear;
- the two operands matching different stages at once.

Load cases cover matches on either decode source, a matching register without a load, and a short pipeline walk that must show one stall and then a write-back bypass. A randomised phase uses a narrow register range so that many matches occur. This phase tells priority errors apart from independence errors between the two operands.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  parameter int REG_W = 5;
  localparam int NUM_OPS = 2;

  typedef logic [REG_W-1:0] regNum_t;

  typedef enum logic [1:0] {
    SEL_FILE = 2'b00,
    SEL_WB   = 2'b01,
    SEL_MEM  = 2'b10
  } fwdSel_t;

  typedef struct packed {
    logic [NUM_OPS-1:0] memHit;
    logic [NUM_OPS-1:0] wbHit;
    logic               loadUse;
  } hitStrobes_t;
endpackage

// File: rtl/hazard_compare.sv
module hazard_compare
  import hazard_pkg::*;
(
  input  regNum_t     idRs,
  input  regNum_t     idRt,
  input  regNum_t     exRs,
  input  regNum_t     exRt,
  input  logic        exMemRead,
  input  regNum_t     memRd,
  input  logic        memRegWrite,
  input  regNum_t     wbRd,
  input  logic        wbRegWrite,
  output hitStrobes_t strobes
);
  localparam regNum_t ZERO_REG = '0;

  regNum_t srcReg [NUM_OPS];
  logic    memLive;
  logic    wbLive;

  assign srcReg[0] = exRs;
  assign srcReg[1] = exRt;

  // A stage can only bypass if it writes and does not target register 0
  assign memLive = memRegWrite && (memRd != ZERO_REG);
  assign wbLive  = wbRegWrite && (wbRd != ZERO_REG);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    assign strobes.memHit[op] = memLive && (memRd == srcReg[op]);
    assign strobes.wbHit[op]  = wbLive && (wbRd == srcReg[op]);
  end

  assign strobes.loadUse = exMemRead && ((exRt == idRs) || (exRt == idRt));
endmodule

// File: rtl/hazard_select.sv
module hazard_select
  import hazard_pkg::*;
(
  input  hitStrobes_t strobes,
  output fwdSel_t     fwdSel [NUM_OPS],
  output logic        stall
);
  for (genvar op = 0; op < NUM_OPS; op++) begin : g_pick
    always_comb begin
      if (strobes.memHit[op]) begin
        fwdSel[op] = SEL_MEM;
      end else if (strobes.wbHit[op]) begin
        fwdSel[op] = SEL_WB;
      end else begin
        fwdSel[op] = SEL_FILE;
      end
    end
  end

  assign stall = strobes.loadUse;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
(
  input  logic [4:0] idRs,
  input  logic [4:0] idRt,
  input  logic [4:0] exRs,
  input  logic [4:0] exRt,
  input  logic       exMemRead,
  input  logic [4:0] memRd,
  input  logic       memRegWrite,
  input  logic [4:0] wbRd,
  input  logic       wbRegWrite,
  output logic [1:0] fwdSelA,
  output logic [1:0] fwdSelB,
  output logic       pcWriteEn,
  output logic       ifidWriteEn,
  output logic       idexCtrlZero
);
  hitStrobes_t strobes;
  fwdSel_t     fwdSel [NUM_OPS];
  logic        stall;

  hazard_compare u_compare (
    .idRs        (idRs),
    .idRt        (idRt),
    .exRs        (exRs),
    .exRt        (exRt),
    .exMemRead   (exMemRead),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .strobes     (strobes)
  );

  hazard_select u_select (
    .strobes (strobes),
    .fwdSel  (fwdSel),
    .stall   (stall)
  );

  assign fwdSelA      = fwdSel[0];
  assign fwdSelB      = fwdSel[1];
  assign pcWriteEn    = !stall;
  assign ifidWriteEn  = !stall;
  assign idexCtrlZero = stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk (
  input logic [4:0] exRs,
  input logic [4:0] exRt,
  input logic       exMemRead,
  input logic [4:0] memRd,
  input logic       memRegWrite,
  input logic [4:0] wbRd,
  input logic       wbRegWrite,
  input logic [1:0] fwdSelA,
  input logic [1:0] fwdSelB,
  input logic       pcWriteEn,
  input logic       ifidWriteEn,
  input logic       idexCtrlZero
);
  always_comb begin
    // R1: a live memory-stage match selects the memory result
    if (memRegWrite && memRd != 5'd0 && memRd == exRs)
      assert_mem_fwd_R1: assert (fwdSelA == 2'b10);
    // R3: with both destinations at register 0 nothing is bypassed
    if (memRd == 5'd0 && wbRd == 5'd0)
      assert_zero_dest_R3: assert (fwdSelA == 2'b00 && fwdSelB == 2'b00);
    // R4: with both write flags clear nothing is bypassed
    if (!memRegWrite && !wbRegWrite)
      assert_no_write_R4: assert (fwdSelA == 2'b00 && fwdSelB == 2'b00);
    // R5: the unused code never appears
    assert_legal_code_R5: assert (fwdSelA != 2'b11 && fwdSelB != 2'b11);
    // R7: the three stall outputs agree
    assert_stall_coherent_R7: assert (pcWriteEn == ifidWriteEn && pcWriteEn != idexCtrlZero);
    // R8: no stall without a load in execute
    if (!exMemRead)
      assert_no_load_R8: assert (pcWriteEn && !idexCtrlZero);
    // R2: the write-back result alone never wins over a memory match on B
    if (memRegWrite && memRd != 5'd0 && memRd == exRt)
      assert_priority_R2: assert (fwdSelB != 2'b01);
  end
endmodule

bind hazard_unit hazard_unit_chk u_chk (
  .exRs         (exRs),
  .exRt         (exRt),
  .exMemRead    (exMemRead),
  .memRd        (memRd),
  .memRegWrite  (memRegWrite),
  .wbRd         (wbRd),
  .wbRegWrite   (wbRegWrite),
  .fwdSelA      (fwdSelA),
  .fwdSelB      (fwdSelB),
  .pcWriteEn    (pcWriteEn),
  .ifidWriteEn  (ifidWriteEn),
  .idexCtrlZero (idexCtrlZero)
);

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [4:0] idRs, idRt, exRs, exRt, memRd, wbRd;
  logic       exMemRead, memRegWrite, wbRegWrite;
  logic [1:0] fwdSelA, fwdSelB;
  logic       pcWriteEn, ifidWriteEn, idexCtrlZero;

  int    total = 0;
  int    bad = 0;
  string phase = "reset";
  bit    done = 1'b0;

  hazard_unit u_dut (
    .idRs(idRs), .idRt(idRt), .exRs(exRs), .exRt(exRt),
    .exMemRead(exMemRead), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .pcWriteEn(pcWriteEn),
    .ifidWriteEn(ifidWriteEn), .idexCtrlZero(idexCtrlZero)
  );

  // Behavioural reference: which source feeds an operand
  function automatic int refSel(int src, int mRd, int mW, int wRd, int wW);
    if (mW != 0 && mRd != 0 && mRd == src) return 2;
    if (wW != 0 && wRd != 0 && wRd == src) return 1;
    return 0;
  endfunction

  function automatic string selTag(int sel, int src);
    if (sel == 2) return "R1";
    if (sel == 1) return "R2";
    if (int'(memRd) == src || int'(wbRd) == src) begin
      if (src == 0) return "R3";
      return "R4";
    end
    return "R5";
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  // Compare every output against the reference on each clock
  always @(posedge clk) begin
    if (!done) begin
      int expA, expB, expStall;
      expA = refSel(int'(exRs), int'(memRd), int'(memRegWrite), int'(wbRd), int'(wbRegWrite));
      expB = refSel(int'(exRt), int'(memRd), int'(memRegWrite), int'(wbRd), int'(wbRegWrite));
      expStall = (exMemRead && (exRt == idRs || exRt == idRt)) ? 1 : 0;
      check(selTag(expA, int'(exRs)), int'(fwdSelA), expA);
      check(selTag(expB, int'(exRt)), int'(fwdSelB), expB);
      check(exMemRead ? "R6" : "R8", int'(pcWriteEn), 1 - expStall);
      check("R7", int'(ifidWriteEn), 1 - expStall);
      check("R7", int'(idexCtrlZero), expStall);
    end
  end

  task automatic apply(string ph, int a, int b, int c, int d, int lr,
                       int m, int mw, int w, int ww);
    @(negedge clk);
    phase = ph;
    idRs = 5'(a); idRt = 5'(b); exRs = 5'(c); exRt = 5'(d); exMemRead = lr != 0;
    memRd = 5'(m); memRegWrite = mw != 0; wbRd = 5'(w); wbRegWrite = ww != 0;
  endtask

  initial begin
    apply("reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 single memory-stage matches on each operand
    apply("R1 mem A", 1, 2, 3, 4, 0, 3, 1, 9, 1);
    apply("R1 mem B", 1, 2, 3, 4, 0, 4, 1, 9, 1);
    // R2 write-back match alone
    apply("R2 wb A", 1, 2, 7, 8, 0, 9, 1, 7, 1);
    // R2 double hazard: memory stage wins on both operands
    apply("R2 double", 1, 2, 5, 5, 0, 5, 1, 5, 1);
    // R3 register zero destinations with writes set
    apply("R3 zero", 0, 0, 0, 0, 0, 0, 1, 0, 1);
    apply("R3 zero mem only", 1, 2, 0, 6, 0, 0, 1, 6, 1);
    // R4 write flags clear
    apply("R4 nowrite", 1, 2, 3, 3, 0, 3, 0, 3, 0);
    apply("R4 mem clear wb live", 1, 2, 3, 4, 0, 3, 0, 3, 1);
    // R9 operands resolve from different stages in the same cycle
    apply("R9 split", 1, 2, 10, 11, 0, 10, 1, 11, 1);
    apply("R9 swap", 1, 2, 11, 10, 0, 10, 1, 11, 1);
    // R6 load-use via each decode source, and via register 0
    apply("R6 rs", 12, 2, 1, 12, 1, 0, 0, 0, 0);
    apply("R6 rt", 1, 12, 1, 12, 1, 0, 0, 0, 0);
    apply("R6 zero", 0, 3, 1, 0, 1, 0, 0, 0, 0);
    apply("R6 miss", 1, 2, 1, 12, 1, 0, 0, 0, 0);
    // R8 register match but no load
    apply("R8 noload", 12, 12, 1, 12, 0, 0, 0, 0, 0);
    // R10 pipeline walk: load r5 then a user of r5
    apply("R10 load in EX", 5, 6, 1, 5, 1, 0, 0, 0, 0);
    apply("R10 bubble in EX", 5, 6, 0, 0, 0, 5, 1, 0, 0);
    apply("R10 user in EX", 7, 8, 5, 6, 0, 0, 0, 5, 1);
    // Randomised phase with a narrow register range
    for (int i = 0; i < 400; i++) begin
      apply("random", int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
            int'($urandom % 4), int'($urandom % 2), int'($urandom % 4),
            int'($urandom % 2), int'($urandom % 4), int'($urandom % 2));
    end
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule